// File: doc/BRIEF.md
# PLL Divider Search Engine

This block works out the feedback multiplier M and the input divider N for a PHY PLL. It takes a requested per-lane data rate and a reference clock frequency, both as unsigned integers in kHz, and a one-cycle start strobe. It first checks that both inputs are in range. It then takes the target output frequency as half the data rate and picks a power-of-two output divider from that target.

Next it walks every allowed N in ascending order. For each N it computes a closest-rounded M and the output frequency that M would give. Candidates that fall outside the M or output-frequency limits are skipped, and the candidate with the smallest absolute error is kept. All the divisions share one multi-cycle restoring divider. A candidate that fails the M check costs one division; a candidate that passes costs two.

When the search ends, the block reports the encoded M and N fields, the chosen divider, the achieved output frequency and an error flag, and it raises done for one cycle. A controller starts a request and waits for done. The reported values stay unchanged until the next request completes.

Top module: `pll_mn_search`

## Requirements
- R1: A request with rate_khz below 80000 or above 2500000 completes with err=1; both limits themselves are accepted.
- R2: A request with fin_khz below 2000 or above 64000 completes with err=1; both limits themselves are accepted.
- R3: A request rejected by R1 or R2 raises done in the second clock cycle after the cycle in which start was sampled.
- R4: The target output frequency is floor(rate_khz/2). With k = ceil(target/80000), the divider is 8/min(k,8), which gives 8, 4, 2 or 1. out_div reports the divider as its plain binary value.
- R5: N is tried from ceil(fin_khz/8000) up to floor(fin_khz/2000), with each bound clamped to 1..16.
- R6: For each N, M = floor((target*N*div + floor(fin_khz/2)) / fin_khz). The candidate is skipped if M is outside 64..625.
- R7: The achieved frequency is floor(M*fin_khz/(N*div)). The candidate is skipped if this is outside 40000..1250000 kHz. fout_khz reports the achieved frequency of the winning candidate.
- R8: A candidate replaces the best one only if its absolute error is strictly smaller, so the lowest N wins a tie.
- R9: If no candidate survives the checks of R6 and R7, the request completes with err=1.
- R10: On success, m_code = M-2 (10 bits) and n_code = N-1 (4 bits). On any error, m_code, n_code, out_div and fout_khz are all zero.
- R11: start is ignored while busy is high. busy goes high in the cycle after start is accepted and is low again in the cycle that done is high.
- R12: done is high for exactly one cycle per request. After reset all outputs are zero. The outputs change only in a cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| rate_khz | input | 24 | Requested per-lane data rate in kHz |
| fin_khz | input | 24 | Reference clock frequency in kHz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected or no valid candidate |
| m_code | output | 10 | Encoded feedback multiplier, M-2 |
| n_code | output | 4 | Encoded input divider, N-1 |
| out_div | output | 4 | Output divider value: 1, 2, 4 or 8 |
| fout_khz | output | 24 | Achieved PLL output frequency in kHz |

## Verification
For a rejected range, done is due exactly two cycles after start is sampled. The bench samples at that falling edge and also checks that done was still low one edge earlier. A full search takes a variable number of cycles: each division costs about 35 cycles, and the number of divisions depends on the N range and on how many candidates pass the M check. The bench therefore polls done on every falling edge up to a fixed bound, then checks that done drops on the next edge and that the results stay unchanged while the inputs move. Expected values come from an integer model of the requirements that is evaluated in the bench.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  // Top-level control sequence of the search engine
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } srch_state_t;

  // Which quantity the shared divider is currently producing
  typedef enum logic [1:0] {
    OP_NLO,   // lowest N bound
    OP_NHI,   // highest N bound
    OP_MUL,   // rounded feedback multiplier
    OP_ACH    // achieved output frequency
  } div_op_t;

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         valid
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  dsr;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shl;
  logic [W-1:0]  diff;
  logic          fits;

  // One quotient bit per cycle; the remainder always stays below the divisor
  assign shl  = {rem, quo[W-1]};
  assign fits = (shl >= {1'b0, dsr});
  assign diff = W'(shl - {1'b0, dsr});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      dsr   <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        rem <= '0;
        dsr <= den;
        quo <= num;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff : shl[W-1:0];
        quo <= {quo[W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_div_select.sv
module pll_div_select #(
  parameter int          FREQ_W   = 24,
  parameter int unsigned STEP_KHZ = 80000
) (
  input  logic [FREQ_W-1:0] fout,
  output logic [1:0]        shift
);
  // Bands of ceil(fout/STEP): 1 -> /8, 2 -> /4, 3..4 -> /2, above -> /1
  localparam logic [FREQ_W-1:0] BAND1 = FREQ_W'(STEP_KHZ);
  localparam logic [FREQ_W-1:0] BAND2 = FREQ_W'(2 * STEP_KHZ);
  localparam logic [FREQ_W-1:0] BAND4 = FREQ_W'(4 * STEP_KHZ);

  always_comb begin
    if (fout <= BAND1)      shift = 2'd3;
    else if (fout <= BAND2) shift = 2'd2;
    else if (fout <= BAND4) shift = 2'd1;
    else                    shift = 2'd0;
  end
endmodule

// File: rtl/pll_best_tracker.sv
module pll_best_tracker #(
  parameter int FREQ_W = 24,
  parameter int M_W    = 10,
  parameter int N_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cand_vld,
  input  logic [M_W-1:0]    cand_m,
  input  logic [N_W-1:0]    cand_n,
  input  logic [FREQ_W-1:0] cand_ach,
  input  logic [FREQ_W-1:0] cand_err,
  output logic              best_vld,
  output logic [M_W-1:0]    best_m,
  output logic [N_W-1:0]    best_n,
  output logic [FREQ_W-1:0] best_ach
);
  logic [FREQ_W-1:0] best_err;
  logic              take;

  // Strictly smaller error only: earlier (lower) N keeps a tie
  assign take = cand_vld && (!best_vld || (cand_err < best_err));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_vld <= 1'b0;
      best_m   <= '0;
      best_n   <= '0;
      best_ach <= '0;
      best_err <= '0;
    end else if (take) begin
      best_vld <= 1'b1;
      best_m   <= cand_m;
      best_n   <= cand_n;
      best_ach <= cand_ach;
      best_err <= cand_err;
    end
  end
endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
  import pll_srch_pkg::*;
#(
  parameter int          FREQ_W       = 24,
  parameter int          M_W          = 10,
  parameter int          NF_W         = 4,
  parameter int unsigned RATE_MIN_KHZ = 80000,
  parameter int unsigned RATE_MAX_KHZ = 2500000,
  parameter int unsigned FIN_MIN_KHZ  = 2000,
  parameter int unsigned FIN_MAX_KHZ  = 64000,
  parameter int unsigned PFD_MIN_KHZ  = 2000,
  parameter int unsigned PFD_MAX_KHZ  = 8000,
  parameter int unsigned M_MIN        = 64,
  parameter int unsigned M_MAX        = 625,
  parameter int unsigned FOUT_MIN_KHZ = 40000,
  parameter int unsigned FOUT_MAX_KHZ = 1250000,
  parameter int unsigned STEP_KHZ     = 80000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] rate_khz,
  input  logic [FREQ_W-1:0] fin_khz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [M_W-1:0]    m_code,
  output logic [NF_W-1:0]   n_code,
  output logic [3:0]        out_div,
  output logic [FREQ_W-1:0] fout_khz
);
  localparam int          N_W    = NF_W + 1;
  localparam int unsigned N_MIN  = 1;
  localparam int unsigned N_MAX  = 1 << NF_W;
  localparam int          PROD_W = (N_W + 4 > M_W) ? (N_W + 4) : M_W;
  localparam int          WIDE_W = FREQ_W + PROD_W;

  localparam logic [FREQ_W-1:0] RATE_LO = FREQ_W'(RATE_MIN_KHZ);
  localparam logic [FREQ_W-1:0] RATE_HI = FREQ_W'(RATE_MAX_KHZ);
  localparam logic [FREQ_W-1:0] FIN_LO  = FREQ_W'(FIN_MIN_KHZ);
  localparam logic [FREQ_W-1:0] FIN_HI  = FREQ_W'(FIN_MAX_KHZ);
  localparam logic [WIDE_W-1:0] M_LO    = WIDE_W'(M_MIN);
  localparam logic [WIDE_W-1:0] M_HI    = WIDE_W'(M_MAX);
  localparam logic [WIDE_W-1:0] FO_LO   = WIDE_W'(FOUT_MIN_KHZ);
  localparam logic [WIDE_W-1:0] FO_HI   = WIDE_W'(FOUT_MAX_KHZ);

  srch_state_t       state;
  div_op_t           op;
  logic [FREQ_W-1:0] rate_q, fin_q, fout_q, fout_tgt;
  logic [1:0]        sh_sel, div_sh_q;
  logic [N_W-1:0]    n_cur, n_lo, n_hi;
  logic [M_W-1:0]    m_cur;
  logic              req_bad;

  logic              dv_go, dv_valid;
  logic [WIDE_W-1:0] dv_num, dv_den, dv_quo;
  logic [WIDE_W-1:0] fout_w, fin_w, n_w, m_w;

  logic              m_fits, ach_fits, cand_vld;
  logic [FREQ_W-1:0] cand_ach, cand_err;
  logic              best_vld;
  logic [M_W-1:0]    best_m;
  logic [N_W-1:0]    best_n;
  logic [FREQ_W-1:0] best_ach;

  function automatic logic [N_W-1:0] clamp_n(input logic [WIDE_W-1:0] q);
    if (q < WIDE_W'(N_MIN))      return N_W'(N_MIN);
    else if (q > WIDE_W'(N_MAX)) return N_W'(N_MAX);
    else                         return q[N_W-1:0];
  endfunction

  assign busy     = (state != ST_IDLE);
  assign fout_tgt = rate_q >> 1;
  assign req_bad  = (rate_q < RATE_LO) || (rate_q > RATE_HI) ||
                    (fin_q < FIN_LO) || (fin_q > FIN_HI);

  pll_div_select #(
    .FREQ_W   (FREQ_W),
    .STEP_KHZ (STEP_KHZ)
  ) sel_i (
    .fout  (fout_tgt),
    .shift (sh_sel)
  );

  // Operand mux for the single shared divider
  assign fout_w = WIDE_W'(fout_q);
  assign fin_w  = WIDE_W'(fin_q);
  assign n_w    = WIDE_W'(n_cur);
  assign m_w    = WIDE_W'(m_cur);
  assign dv_go  = (state == ST_ISSUE);

  always_comb begin
    unique case (op)
      OP_NLO: begin
        dv_num = fin_w + WIDE_W'(PFD_MAX_KHZ - 1);
        dv_den = WIDE_W'(PFD_MAX_KHZ);
      end
      OP_NHI: begin
        dv_num = fin_w;
        dv_den = WIDE_W'(PFD_MIN_KHZ);
      end
      OP_MUL: begin
        dv_num = ((fout_w * n_w) << div_sh_q) + (fin_w >> 1);
        dv_den = fin_w;
      end
      default: begin
        dv_num = m_w * fin_w;
        dv_den = n_w << div_sh_q;
      end
    endcase
  end

  pll_restoring_div #(
    .W (WIDE_W)
  ) div_i (
    .clk   (clk),
    .rst   (rst),
    .go    (dv_go),
    .num   (dv_num),
    .den   (dv_den),
    .quo   (dv_quo),
    .valid (dv_valid)
  );

  // Candidate qualification
  assign m_fits   = (dv_quo >= M_LO) && (dv_quo <= M_HI);
  assign ach_fits = (dv_quo >= FO_LO) && (dv_quo <= FO_HI);
  assign cand_ach = FREQ_W'(dv_quo);
  assign cand_err = (fout_q > cand_ach) ? (fout_q - cand_ach) : (cand_ach - fout_q);
  assign cand_vld = (state == ST_WAIT) && dv_valid && (op == OP_ACH) && ach_fits;

  pll_best_tracker #(
    .FREQ_W (FREQ_W),
    .M_W    (M_W),
    .N_W    (N_W)
  ) best_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (state == ST_CHECK),
    .cand_vld (cand_vld),
    .cand_m   (m_cur),
    .cand_n   (n_cur),
    .cand_ach (cand_ach),
    .cand_err (cand_err),
    .best_vld (best_vld),
    .best_m   (best_m),
    .best_n   (best_n),
    .best_ach (best_ach)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op       <= OP_NLO;
      rate_q   <= '0;
      fin_q    <= '0;
      fout_q   <= '0;
      div_sh_q <= '0;
      n_cur    <= '0;
      n_lo     <= '0;
      n_hi     <= '0;
      m_cur    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      m_code   <= '0;
      n_code   <= '0;
      out_div  <= '0;
      fout_khz <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            rate_q <= rate_khz;
            fin_q  <= fin_khz;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (req_bad) begin
            done     <= 1'b1;
            err      <= 1'b1;
            m_code   <= '0;
            n_code   <= '0;
            out_div  <= '0;
            fout_khz <= '0;
            state    <= ST_IDLE;
          end else begin
            fout_q   <= fout_tgt;
            div_sh_q <= sh_sel;
            op       <= OP_NLO;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (dv_valid) begin
            unique case (op)
              OP_NLO: begin
                n_lo  <= clamp_n(dv_quo);
                op    <= OP_NHI;
                state <= ST_ISSUE;
              end
              OP_NHI: begin
                n_hi  <= clamp_n(dv_quo);
                n_cur <= n_lo;
                if (n_lo > clamp_n(dv_quo)) begin
                  state <= ST_FINISH;
                end else begin
                  op    <= OP_MUL;
                  state <= ST_ISSUE;
                end
              end
              OP_MUL: begin
                m_cur <= M_W'(dv_quo);
                if (m_fits) begin
                  op    <= OP_ACH;
                  state <= ST_ISSUE;
                end else if (n_cur == n_hi) begin
                  state <= ST_FINISH;
                end else begin
                  n_cur <= n_cur + 1'b1;
                  op    <= OP_MUL;
                  state <= ST_ISSUE;
                end
              end
              default: begin
                if (n_cur == n_hi) begin
                  state <= ST_FINISH;
                end else begin
                  n_cur <= n_cur + 1'b1;
                  op    <= OP_MUL;
                  state <= ST_ISSUE;
                end
              end
            endcase
          end
        end
        ST_FINISH: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (best_vld) begin
            err      <= 1'b0;
            m_code   <= best_m - M_W'(2);
            n_code   <= NF_W'(best_n - N_W'(1));
            out_div  <= 4'b0001 << div_sh_q;
            fout_khz <= best_ach;
          end else begin
            err      <= 1'b1;
            m_code   <= '0;
            n_code   <= '0;
            out_div  <= '0;
            fout_khz <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_mn_search_chk.sv
module pll_mn_search_chk #(
  parameter int          FREQ_W       = 24,
  parameter int          M_W          = 10,
  parameter int unsigned M_MIN        = 64,
  parameter int unsigned M_MAX        = 625,
  parameter int unsigned FOUT_MIN_KHZ = 40000,
  parameter int unsigned FOUT_MAX_KHZ = 1250000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [M_W-1:0]    m_code,
  input logic [3:0]        out_div,
  input logic [FREQ_W-1:0] fout_khz
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R12

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(m_code) && $stable(out_div) && $stable(fout_khz) && $stable(err)));  // R12

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R11

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);  // R11

  AST_M_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((m_code >= M_W'(M_MIN - 2)) && (m_code <= M_W'(M_MAX - 2))));  // R6

  AST_DIV_POW2: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ($countones(out_div) == 1));  // R4

  AST_FOUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((fout_khz >= FREQ_W'(FOUT_MIN_KHZ)) && (fout_khz <= FREQ_W'(FOUT_MAX_KHZ))));  // R7

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ((m_code == '0) && (out_div == '0) && (fout_khz == '0)));  // R10
endmodule

bind pll_mn_search pll_mn_search_chk #(
  .FREQ_W       (FREQ_W),
  .M_W          (M_W),
  .M_MIN        (M_MIN),
  .M_MAX        (M_MAX),
  .FOUT_MIN_KHZ (FOUT_MIN_KHZ),
  .FOUT_MAX_KHZ (FOUT_MAX_KHZ)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .m_code   (m_code),
  .out_div  (out_div),
  .fout_khz (fout_khz)
);

// File: tb/pll_mn_search_tb.sv
module pll_mn_search_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] rate_khz = '0;
  logic [23:0] fin_khz = '0;
  logic        busy, done, err;
  logic [9:0]  m_code;
  logic [3:0]  n_code;
  logic [3:0]  out_div;
  logic [23:0] fout_khz;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pll_mn_search dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rate_khz (rate_khz),
    .fin_khz  (fin_khz),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .m_code   (m_code),
    .n_code   (n_code),
    .out_div  (out_div),
    .fout_khz (fout_khz)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Integer model written from the requirements
  task automatic model(input longint rate, input longint fin, output longint em,
                       output longint en, output longint ediv, output longint each,
                       output bit eerr);
    longint fout, k, lo, hi, m, a, d, bd;
    bit bv;
    em = 0; en = 0; ediv = 0; each = 0; bv = 0; bd = 0;
    if (rate < 80000 || rate > 2500000 || fin < 2000 || fin > 64000) begin
      eerr = 1;
      return;
    end
    fout = rate / 2;
    k = (fout + 79999) / 80000;
    if (k > 8) k = 8;
    ediv = 8 / k;
    lo = (fin + 7999) / 8000;
    hi = fin / 2000;
    if (lo < 1) lo = 1;
    if (lo > 16) lo = 16;
    if (hi < 1) hi = 1;
    if (hi > 16) hi = 16;
    for (longint n = lo; n <= hi; n++) begin
      m = (fout * n * ediv + fin / 2) / fin;
      if (m < 64 || m > 625) continue;
      a = (m * fin) / (n * ediv);
      if (a < 40000 || a > 1250000) continue;
      d = (fout > a) ? fout - a : a - fout;
      if (!bv || d < bd) begin
        bv = 1; bd = d; em = m; en = n; each = a;
      end
    end
    eerr = !bv;
    if (!bv) ediv = 0;
  endtask

  task automatic launch(input longint rate, input longint fin);
    @(negedge clk);
    rate_khz = 24'(rate);
    fin_khz  = 24'(fin);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", longint'(busy), 1);
  endtask

  task automatic wait_done(output int cyc, output bit seen);
    seen = 0;
    cyc  = 0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        cyc  = i;
        break;
      end
    end
  endtask

  task automatic run_req(input longint rate, input longint fin, input string tag);
    longint em, en, ediv, each;
    bit eerr, seen;
    int cyc;
    model(rate, fin, em, en, ediv, each, eerr);
    launch(rate, fin);
    wait_done(cyc, seen);
    chk(seen, {tag, " done seen"}, longint'(seen), 1);
    if (seen) begin
      chk(err == eerr, {tag, " err"}, longint'(err), longint'(eerr));
      if (!eerr) begin
        chk(m_code == 10'(em - 2), "R10 m_code", longint'(m_code), em - 2);
        chk(n_code == 4'(en - 1), "R10 n_code", longint'(n_code), en - 1);
        chk(out_div == 4'(ediv), "R4 out_div", longint'(out_div), ediv);
        chk(fout_khz == 24'(each), "R7 fout_khz", longint'(fout_khz), each);
      end else begin
        chk(m_code == 0 && n_code == 0 && out_div == 0 && fout_khz == 0,
            "R10 zero fields on error", longint'(m_code), 0);
      end
      @(negedge clk);
      chk(done == 1'b0, "R12 done one cycle", longint'(done), 0);
      chk(busy == 1'b0, "R11 idle after done", longint'(busy), 0);
    end
  endtask

  task automatic test_reset;
    chk(!busy && !done && !err, "R12 reset flags", longint'({busy, done, err}), 0);
    chk(m_code == 0 && n_code == 0 && out_div == 0 && fout_khz == 0,
        "R12 reset fields", longint'(fout_khz), 0);
  endtask

  // Range rejection with exact completion latency
  task automatic reject_latency(input longint rate, input longint fin, input string tag);
    launch(rate, fin);
    chk(done == 1'b0, "R3 done not early", longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R3 done latency", longint'(done), 1);
    chk(err == 1'b1, {tag, " range error"}, longint'(err), 1);
    chk(m_code == 0 && out_div == 0 && fout_khz == 0, "R10 zeros on reject",
        longint'(fout_khz), 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", longint'(done), 0);
  endtask

  task automatic test_rate_limits;
    reject_latency(79999, 24000, "R1 low");
    reject_latency(2500001, 24000, "R1 high");
    run_req(80000, 24000, "R1 low limit");
    run_req(2500000, 24000, "R1 high limit");
  endtask

  task automatic test_fin_limits;
    reject_latency(1000000, 1999, "R2 low");
    reject_latency(1000000, 64001, "R2 high");
    run_req(1000000, 2000, "R2 R5 single N");
    run_req(1000000, 64000, "R2 R5 clamp high");
  endtask

  task automatic test_tie;
    run_req(1000000, 24000, "R8 tie");
    chk(n_code == 4'd5, "R8 lowest N wins", longint'(n_code), 5);
    chk(m_code == 10'd123, "R8 matching M", longint'(m_code), 123);
  endtask

  task automatic test_no_candidate;
    run_req(2499998, 2001, "R9 none survive");
    chk(err == 1'b1, "R9 err set", longint'(err), 1);
  endtask

  task automatic test_sweep;
    run_req(150000, 27000, "R4 R6 div8");
    run_req(300000, 19200, "R4 R6 div4");
    run_req(600000, 25000, "R4 R6 div2");
    run_req(891000, 24000, "R6 R7 div1");
    run_req(445500, 26000, "R5 R6 mixed");
  endtask

  task automatic test_busy_ignore;
    longint em, en, ediv, each;
    bit eerr, seen;
    int cyc;
    model(1200000, 24000, em, en, ediv, each, eerr);
    launch(1200000, 24000);
    repeat (5) @(negedge clk);
    rate_khz = 24'd300000;
    fin_khz  = 24'd19200;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 still busy", longint'(busy), 1);
    wait_done(cyc, seen);
    chk(seen, "R11 done seen", longint'(seen), 1);
    chk(fout_khz == 24'(each), "R11 first request kept", longint'(fout_khz), each);
    chk(m_code == 10'(em - 2), "R11 first request M", longint'(m_code), em - 2);
    @(negedge clk);
    chk(!busy && !done, "R11 no second run", longint'(busy), 0);
  endtask

  task automatic test_hold;
    logic [9:0]  m_s;
    logic [3:0]  n_s, d_s;
    logic [23:0] f_s;
    run_req(700000, 24000, "R12 base");
    m_s = m_code; n_s = n_code; d_s = out_div; f_s = fout_khz;
    rate_khz = 24'd100;
    fin_khz  = 24'd5;
    repeat (20) @(negedge clk);
    chk(m_code == m_s && n_code == n_s && out_div == d_s && fout_khz == f_s && !err,
        "R12 outputs hold", longint'(fout_khz), longint'(f_s));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_rate_limits();
    test_fin_limits();
    test_tie();
    test_no_candidate();
    test_sweep();
    test_busy_ignore();
    test_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule